// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block watches sixteen external interrupt lines and turns their activity into three interrupt requests for a parent controller. Each input first passes through a two-flop synchronizer. Each pair of neighbouring lines shares one trigger code. The code selects rising-edge, falling-edge, both-edge, low-level or high-level detection, or no detection at all. A detected event puts that line into a pending state. The line stays there until software acknowledges it by writing a 1 to its bit.

Each line is a two-state machine. `LN_CLEAR` moves to `LN_PENDING` on the transition *raise*, which fires on a detected event when no acknowledge is present. `LN_PENDING` moves back to `LN_CLEAR` on the transition *ack*, which fires on a write of 1 to the line's pending bit. If neither happens, the line holds its state. An acknowledge takes priority over an event in the same cycle. A per-line mask decides which pending lines take part in the outputs. Lines 0–3 are ORed onto the first output, lines 4–11 onto the second, and lines 12–15 onto the third.

Software reaches the block through a small word-addressed register port. Writes take effect on the clock edge. Reads are combinational.

Top module: `eint_ctrl`

## Requirements
- R1: After reset the mask reads 0x0000FFFF, pending reads 0, configuration reads 0x77777777 (every line disabled), and all three group outputs are 0.
- R2: Lines 2k and 2k+1 share the 3-bit trigger code at configuration bits [4k+2:4k]. Bit 4k+3 always reads 0 and ignores writes.
- R3: Code 4 (rising) sets pending on a 0→1 input change and not on a 1→0 change.
- R4: Code 2 (falling) sets pending on a 1→0 change and not on a 0→1 change.
- R5: Code 6 (both edges) sets pending on either change.
- R6: Code 1 (high level) sets pending while the input is high. If the input is still high when an acknowledge clears the bit, the bit reads 0 for one cycle and then sets again.
- R7: Code 0 (low level) sets pending while the input is low and not while it is high.
- R8: Codes 3, 5 and 7 never set pending.
- R9: Writing 1 to pending bit i clears it. Writing 0 leaves it unchanged.
- R10: Mask bit 1 keeps a line off its group output while its pending bit still records events. Mask bit 0 lets it through.
- R11: irq_group[0] is the OR of unmasked pending lines 0–3, irq_group[1] covers lines 4–11, and irq_group[2] covers lines 12–15.
- R12: An input change shows in pending and in the group output after exactly three rising clock edges.
- R13: Word offsets are 0x0 configuration, 0x4 mask, 0x8 pending. Offset 0xC and misaligned addresses read 0 and ignore writes. Mask and pending bits above 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 16 | External interrupt lines, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| irq_group | output | 3 | Grouped interrupt requests to the parent |

## Verification
A line machine stuck in the wrong state shows in the pending register on the next read. It also shows on its group output at the same edge, unless that line is masked. A wrong trigger decode or a wrong field position appears three edges after the input change, as a pending bit that is missing, extra, or set on the wrong line. A grouping error appears as the wrong irq_group bit for a line at a group boundary, which the vectors cover at lines 3, 4, 11 and 12.

// File: rtl/eint_pkg.sv
package eint_pkg;
    localparam logic [2:0] TRIG_LOW  = 3'd0;
    localparam logic [2:0] TRIG_HIGH = 3'd1;
    localparam logic [2:0] TRIG_FALL = 3'd2;
    localparam logic [2:0] TRIG_RISE = 3'd4;
    localparam logic [2:0] TRIG_BOTH = 3'd6;
    localparam logic [2:0] TRIG_OFF  = 3'd7;

    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_PEND = 2'd2;

    typedef enum logic {LN_CLEAR, LN_PENDING} line_state_e;
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
    parameter int NLINES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] async_i,
    output logic [NLINES-1:0] sync_o
);
    logic [NLINES-1:0] stage1_q;
    logic [NLINES-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/eint_detect.sv
module eint_detect
    import eint_pkg::*;
#(
    parameter int NLINES = 16,
    localparam int NPAIRS = NLINES / 2,
    localparam int CFG_W  = NPAIRS * 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] sync_i,
    input  logic [CFG_W-1:0]  cfg_i,
    output logic [NLINES-1:0] event_o
);
    logic [NLINES-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_i;
    end

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic [2:0] code;
        logic       rise;
        logic       fall;
        assign code = cfg_i[4*(i/2) +: 3];
        assign rise = sync_i[i] & ~prev_q[i];
        assign fall = ~sync_i[i] & prev_q[i];

        always_comb begin
            unique case (code)
                TRIG_LOW:  event_o[i] = ~sync_i[i];
                TRIG_HIGH: event_o[i] = sync_i[i];
                TRIG_FALL: event_o[i] = fall;
                TRIG_RISE: event_o[i] = rise;
                TRIG_BOTH: event_o[i] = rise | fall;
                default:   event_o[i] = 1'b0;
            endcase
        end

        // R3
        rise_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code == TRIG_RISE && event_o[i]) |-> $rose(sync_i[i]));
        // R4
        fall_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (code == TRIG_FALL && event_o[i]) |-> $fell(sync_i[i]));
    end
endmodule

// File: rtl/eint_line_fsm.sv
module eint_line_fsm
    import eint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic ack_i,
    output logic pending_o
);
    line_state_e state_q;
    line_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_CLEAR:   if (event_i && !ack_i) state_d = LN_PENDING;
            LN_PENDING: if (ack_i)             state_d = LN_CLEAR;
            default:                           state_d = LN_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        pending_o = (state_q == LN_PENDING);
    end

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !pending_o);
    // R6
    set_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (event_i && !ack_i) |=> pending_o);
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending_o && !event_i) |=> !pending_o);
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NLINES    = 16,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int GRP0_LAST = 3,
    parameter int GRP1_LAST = 11,
    localparam int NPAIRS   = NLINES / 2,
    localparam int CFG_W    = NPAIRS * 4,
    localparam int NGROUPS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ext_in,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [2:0]        irq_group
);
    function automatic logic [NLINES-1:0] group_bits(input int g);
        logic [NLINES-1:0] m;
        int lo;
        int hi;
        lo = (g == 0) ? 0 : (g == 1) ? GRP0_LAST + 1 : GRP1_LAST + 1;
        hi = (g == 0) ? GRP0_LAST : (g == 1) ? GRP1_LAST : NLINES - 1;
        m = '0;
        for (int i = 0; i < NLINES; i++) m[i] = (i >= lo) && (i <= hi);
        return m;
    endfunction

    logic                  aligned;
    logic [ADDR_W-3:0]     word_sel;
    logic                  wr_cfg, wr_mask, wr_pend;
    logic [2:0]            cfg_q [NPAIRS];
    logic [CFG_W-1:0]      cfg_flat;
    logic [NLINES-1:0]     mask_q;
    logic [NLINES-1:0]     sync_w;
    logic [NLINES-1:0]     event_w;
    logic [NLINES-1:0]     pend_w;
    logic [NLINES-1:0]     active_w;
    logic                  unused_wdata;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign word_sel = bus_addr[ADDR_W-1:2];
    assign wr_cfg   = bus_we && aligned && (word_sel == (ADDR_W-2)'(SEL_CFG));
    assign wr_mask  = bus_we && aligned && (word_sel == (ADDR_W-2)'(SEL_MASK));
    assign wr_pend  = bus_we && aligned && (word_sel == (ADDR_W-2)'(SEL_PEND));
    assign unused_wdata = ^bus_wdata;

    for (genvar k = 0; k < NPAIRS; k++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      cfg_q[k] <= TRIG_OFF;
            else if (wr_cfg) cfg_q[k] <= bus_wdata[4*k +: 3];
        end
        assign cfg_flat[4*k +: 4] = {1'b0, cfg_q[k]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '1;
        else if (wr_mask) mask_q <= bus_wdata[NLINES-1:0];
    end

    eint_sync #(.NLINES(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_in),
        .sync_o  (sync_w)
    );

    eint_detect #(.NLINES(NLINES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_w),
        .cfg_i   (cfg_flat),
        .event_o (event_w)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_fsm
        eint_line_fsm u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .event_i   (event_w[i]),
            .ack_i     (wr_pend && bus_wdata[i]),
            .pending_o (pend_w[i])
        );
    end

    assign active_w = pend_w & ~mask_q;

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        localparam logic [NLINES-1:0] GMASK = group_bits(g);
        assign irq_group[g] = |(active_w & GMASK);
    end

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            unique case (word_sel)
                (ADDR_W-2)'(SEL_CFG):  bus_rdata = DATA_W'(cfg_flat);
                (ADDR_W-2)'(SEL_MASK): bus_rdata = DATA_W'(mask_q);
                (ADDR_W-2)'(SEL_PEND): bus_rdata = DATA_W'(pend_w);
                default:               bus_rdata = '0;
            endcase
        end
    end

    // R13
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));
    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cfg |=> $stable(cfg_flat));
endmodule

// File: tb/sim_eint_ctrl.sv
`timescale 1ns/1ps
module sim_eint_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ext_in = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_group;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    eint_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_group(irq_group)
    );

    // {line[3:0], code[2:0], before, after, expect_pending, group[2:0]}
    localparam int NV = 15;
    localparam logic [12:0] VEC [NV] = '{
        {4'd0,  3'd4, 1'b0, 1'b1, 1'b1, 3'b001},
        {4'd1,  3'd4, 1'b1, 1'b0, 1'b0, 3'b000},
        {4'd5,  3'd2, 1'b1, 1'b0, 1'b1, 3'b010},
        {4'd6,  3'd2, 1'b0, 1'b1, 1'b0, 3'b000},
        {4'd12, 3'd6, 1'b0, 1'b1, 1'b1, 3'b100},
        {4'd13, 3'd6, 1'b1, 1'b0, 1'b1, 3'b100},
        {4'd8,  3'd1, 1'b0, 1'b1, 1'b1, 3'b010},
        {4'd9,  3'd1, 1'b1, 1'b0, 1'b0, 3'b000},
        {4'd3,  3'd0, 1'b1, 1'b0, 1'b1, 3'b001},
        {4'd15, 3'd0, 1'b0, 1'b1, 1'b0, 3'b000},
        {4'd10, 3'd3, 1'b0, 1'b1, 1'b0, 3'b000},
        {4'd2,  3'd5, 1'b1, 1'b0, 1'b0, 3'b000},
        {4'd14, 3'd7, 1'b0, 1'b1, 1'b0, 3'b000},
        {4'd11, 3'd6, 1'b0, 1'b1, 1'b1, 3'b010},
        {4'd4,  3'd4, 1'b0, 1'b1, 1'b1, 3'b010}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string code_tag(input logic [2:0] c);
        case (c)
            3'd4: return "R3";
            3'd2: return "R4";
            3'd6: return "R5";
            3'd1: return "R6";
            3'd0: return "R7";
            default: return "R8";
        endcase
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=finish", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        cycles_n(3);
        rst_n = 1'b1;
        cycles_n(1);

        // R1 reset state
        rd(4'h0, r); check("R1 cfg", r, 32'h77777777);
        rd(4'h4, r); check("R1 mask", r, 32'h0000FFFF);
        rd(4'h8, r); check("R1 pend", r, 32'h0);
        check("R1 groups", {29'b0, irq_group}, 32'h0);
        rd(4'hC, r); check("R13 unused offset", r, 32'h0);

        // R2 field layout
        wr(4'h0, 32'hFFFFFFFF); rd(4'h0, r); check("R2 stride bits", r, 32'h77777777);
        wr(4'h0, 32'h01234567); rd(4'h0, r); check("R2 fields", r, 32'h01234567);
        wr(4'h0, 32'h77777777);

        // R13 mask width and misaligned access
        wr(4'h4, 32'hFFFFFFFF); rd(4'h4, r); check("R13 mask upper", r, 32'h0000FFFF);
        wr(4'h5, 32'h0); rd(4'h4, r); check("R13 misaligned write", r, 32'h0000FFFF);
        rd(4'h6, r); check("R13 misaligned read", r, 32'h0);

        wr(4'h4, 32'h0);
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  ln;
            logic [2:0]  code, grp;
            logic        bef, aft, exp_p, idle;
            logic [31:0] cfgv;
            {ln, code, bef, aft, exp_p, grp} = VEC[v];
            idle = (code == 3'd0);
            cfgv = (32'h77777777 & ~(32'h7 << (4 * (ln / 2)))) | (32'(code) << (4 * (ln / 2)));
            wr(4'h0, 32'h77777777);
            ext_in = {16{idle}};
            ext_in[ln] = bef;
            cycles_n(5);
            wr(4'h8, 32'h0000FFFF);
            if (code == 3'd0 || code == 3'd1) begin
                ext_in[ln] = aft;
                cycles_n(4);
                wr(4'h0, cfgv);
            end else begin
                wr(4'h0, cfgv);
                ext_in[ln] = aft;
            end
            cycles_n(4);
            rd(4'h8, r);
            check(code_tag(code), r, 32'(exp_p) << ln);
            check("R11 group", {29'b0, irq_group}, {29'b0, grp});
        end

        // R12 latency on line 0, rising
        wr(4'h0, 32'h77777774);
        ext_in = '0;
        cycles_n(4);
        wr(4'h8, 32'h0000FFFF);
        ext_in[0] = 1'b1;
        cycles_n(1); rd(4'h8, r); check("R12 edge1", r, 32'h0);
        cycles_n(1); rd(4'h8, r); check("R12 edge2", r, 32'h0);
        check("R12 group edge2", {29'b0, irq_group}, 32'h0);
        cycles_n(1); rd(4'h8, r); check("R12 edge3", r, 32'h1);
        check("R12 group edge3", {29'b0, irq_group}, 32'h1);

        // R9 write of zero keeps, write of one clears
        wr(4'h8, 32'h0); rd(4'h8, r); check("R9 zero write", r, 32'h1);
        wr(4'h8, 32'h1); rd(4'h8, r); check("R9 one write", r, 32'h0);

        // R10 mask gating
        wr(4'h4, 32'h1);
        ext_in[0] = 1'b0; cycles_n(4);
        ext_in[0] = 1'b1; cycles_n(4);
        rd(4'h8, r); check("R10 pending while masked", r, 32'h1);
        check("R10 masked group", {29'b0, irq_group}, 32'h0);
        wr(4'h4, 32'h0);
        check("R10 unmasked group", {29'b0, irq_group}, 32'h1);
        wr(4'h8, 32'hFFFF);

        // R6 level high re-asserts after ack
        wr(4'h0, 32'h77717777);
        ext_in[8] = 1'b1;
        cycles_n(4);
        rd(4'h8, r); check("R6 level set", r, 32'h100);
        wr(4'h8, 32'h100);
        rd(4'h8, r); check("R6 cleared cycle", r, 32'h0);
        cycles_n(1);
        rd(4'h8, r); check("R6 re-set", r, 32'h100);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule